// File: doc/BRIEF.md
# Peripheral Clock Slot Controller

This block owns the clock configuration of a single peripheral slot. A 32-bit configuration word selects one of four gating modes, picks one of four functional clock sources, sets an integer divider and controls the reset line of the peripheral. From this it produces a registered clock-gate enable, a divided functional-clock enable pulse and an active-low peripheral reset.

The block also answers the system low-power entry handshake. It watches the sleep and deep-sleep requests and the peripheral's idle flag. It raises a stall while entry must wait for the peripheral to go idle, and it raises an acknowledge once entry may proceed. Clock sources reach the block as per-source tick strobes in the `clk` domain. The functional-clock enable is the selected tick thinned by the divider, so an outside clock cell can use it as a gate condition.

Top module: `pclk_slot_ctrl`

## Requirements
- R1: A synchronous reset clears every writable field to zero. After reset `clk_gate_on`, `fclk_en`, `lp_stall`, `lp_ack` and `periph_rst_n` are 0, and `cfg_rdata` reads only the present bit.
- R2: Mode 0 (bits [1:0] = 0) holds `clk_gate_on` low, never stalls, and clears the divider count.
- R3: Mode 1 holds `clk_gate_on` high one cycle after the mode is in place, and never stalls.
- R4: In mode 2, `clk_gate_on` is the registered inverse of `periph_idle`. Either low-power request stalls entry while the peripheral is busy.
- R5: In mode 3 with the keep-in-sleep bit (bit 3) clear, either request counts as low-power entry. The gate turns off only when entry is requested and the peripheral is idle, and entry stalls while it is busy.
- R6: In mode 3 with the keep-in-sleep bit set, a sleep request without a deep-sleep request keeps the gate on and does not stall. A deep-sleep request behaves as in R5.
- R7: `lp_stall` and `lp_ack` are registered. `lp_stall` is low in the cycle after `periph_idle` is seen high. `lp_ack` is high in the cycle after any request is seen with no stall condition, and the two are never high together.
- R8: A write updates the source field (bits [6:4]) and the divider field (bits [15:8]) only if the mode held before the write is 0. Mode, release and keep-in-sleep are always written. Readback returns the held fields in these positions.
- R9: Source codes 2, 3, 4 and 5 select `src_ticks[0]`, `[1]`, `[2]` and `[3]` respectively (6 MHz, 192 MHz, external, 32 kHz). Any other code selects no source, so `fclk_en` stays low.
- R10: While the gate is on, `fclk_en` pulses for one cycle on every (divider+1)-th selected tick, one cycle after that tick. It is never high without a gated tick in the previous cycle.
- R11: Bit 2 releases the peripheral from reset (`periph_rst_n` follows it). Bit 31 is a read-only present bit that reads as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration readback |
| src_ticks | input | 4 | One tick strobe per clock source |
| sleep_req | input | 1 | System sleep request |
| deep_req | input | 1 | System deep-sleep request |
| periph_idle | input | 1 | Peripheral reports idle |
| clk_gate_on | output | 1 | Registered clock-gate enable |
| fclk_en | output | 1 | Divided functional-clock enable pulse |
| periph_rst_n | output | 1 | Active-low peripheral reset |
| lp_stall | output | 1 | Low-power entry must wait |
| lp_ack | output | 1 | Low-power entry may proceed |

## Verification
A configuration write that changes the mode can land in the same cycle as a change in a low-power request or in the idle flag. The gate, stall and acknowledge for that cycle must then come from the old mode, and the new mode takes effect one cycle later. A write that retargets the source or divider can also coincide with a selected tick. Random stimulus issues writes at a steady rate while the requests, idle and ticks toggle freely, so these overlaps occur many times. A cycle-level reference model built from the requirements judges every output on every cycle.

// File: rtl/pclk_slot_pkg.sv
package pclk_slot_pkg;

  typedef enum logic [1:0] {
    GM_OFF   = 2'd0,
    GM_ON    = 2'd1,
    GM_IDLE  = 2'd2,
    GM_SLEEP = 2'd3
  } gate_mode_e;

  localparam int          NUM_SRC  = 4;
  localparam int          SRC_W    = 3;
  localparam logic [2:0]  SRC_BASE = 3'd2;

  localparam int MODE_LSB = 0;
  localparam int REL_BIT  = 2;
  localparam int HOLD_BIT = 3;
  localparam int SRC_LSB  = 4;
  localparam int DIV_LSB  = 8;

endpackage

// File: rtl/pclk_cfg_reg.sv
module pclk_cfg_reg
  import pclk_slot_pkg::*;
#(
  parameter int   REG_W   = 32,
  parameter int   DIV_W   = 8,
  parameter logic PRESENT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [REG_W-1:0]  wdata,
  output logic [1:0]        mode_q,
  output logic              rel_q,
  output logic              hold_q,
  output logic [SRC_W-1:0]  src_q,
  output logic [DIV_W-1:0]  div_q,
  output logic [REG_W-1:0]  rdata
);

  localparam int PRES_BIT = REG_W - 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      rel_q  <= 1'b0;
      hold_q <= 1'b0;
      src_q  <= '0;
      div_q  <= '0;
    end else if (we) begin
      mode_q <= wdata[MODE_LSB +: 2];
      rel_q  <= wdata[REL_BIT];
      hold_q <= wdata[HOLD_BIT];
      // mux and divider only move while the clock is gated off
      if (mode_q == GM_OFF) begin
        src_q <= wdata[SRC_LSB +: SRC_W];
        div_q <= wdata[DIV_LSB +: DIV_W];
      end
    end
  end

  always_comb begin
    rdata                      = '0;
    rdata[MODE_LSB +: 2]       = mode_q;
    rdata[REL_BIT]             = rel_q;
    rdata[HOLD_BIT]            = hold_q;
    rdata[SRC_LSB +: SRC_W]    = src_q;
    rdata[DIV_LSB +: DIV_W]    = div_q;
    rdata[PRES_BIT]            = PRESENT;
  end

  // R1: reset empties the writable fields
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (mode_q == GM_OFF && !rel_q && !hold_q && src_q == '0 && div_q == '0));

  // R8: source and divider frozen while mode is nonzero
  p_src_locked_r8: assert property (@(posedge clk) disable iff (rst)
    (mode_q != GM_OFF) |=> ($stable(src_q) && $stable(div_q)));

endmodule

// File: rtl/pclk_lp_gate.sv
module pclk_lp_gate
  import pclk_slot_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode,
  input  logic       hold,
  input  logic       sleep_req,
  input  logic       deep_req,
  input  logic       idle,
  output logic       gate_on,
  output logic       stall,
  output logic       ack
);

  logic lp_any;
  logic lp_eff;
  logic need_stall;
  logic gate_nxt;

  always_comb begin
    lp_any = sleep_req | deep_req;
    unique case (mode)
      GM_IDLE:  lp_eff = lp_any;
      GM_SLEEP: lp_eff = deep_req | (sleep_req & ~hold);
      default:  lp_eff = 1'b0;
    endcase
    need_stall = lp_eff & ~idle;
    unique case (mode)
      GM_OFF:   gate_nxt = 1'b0;
      GM_ON:    gate_nxt = 1'b1;
      GM_IDLE:  gate_nxt = ~idle;
      default:  gate_nxt = ~(lp_eff & idle);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_on <= 1'b0;
      stall   <= 1'b0;
      ack     <= 1'b0;
    end else begin
      gate_on <= gate_nxt;
      stall   <= need_stall;
      ack     <= lp_any & ~need_stall;
    end
  end

  // R2: mode 0 keeps the gate closed
  p_off_gated_r2: assert property (@(posedge clk) disable iff (rst)
    (mode == GM_OFF) |=> !gate_on);

  // R3: mode 1 keeps the gate open with no stall
  p_on_running_r3: assert property (@(posedge clk) disable iff (rst)
    (mode == GM_ON) |=> (gate_on && !stall));

  // R4: busy peripheral under a request stalls in mode 2
  p_busy_stall_r4: assert property (@(posedge clk) disable iff (rst)
    (mode == GM_IDLE && (sleep_req || deep_req) && !idle) |=> stall);

  // R6: plain sleep with keep-in-sleep neither gates nor stalls
  p_hold_sleep_r6: assert property (@(posedge clk) disable iff (rst)
    (mode == GM_SLEEP && hold && sleep_req && !deep_req) |=> (gate_on && !stall));

  // R7: idle seen releases the stall next cycle
  p_idle_unstall_r7: assert property (@(posedge clk) disable iff (rst)
    idle |=> !stall);

  // R7: stall and acknowledge never together
  p_stall_ack_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(stall && ack));

endmodule

// File: rtl/pclk_fclk_div.sv
module pclk_fclk_div
  import pclk_slot_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               gate_on,
  input  logic [SRC_W-1:0]   src,
  input  logic [DIV_W-1:0]   div,
  input  logic [NUM_SRC-1:0] src_ticks,
  output logic               fclk_en
);

  logic [NUM_SRC-1:0] hit;
  logic               sel_tick;
  logic [DIV_W-1:0]   cnt;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    localparam logic [SRC_W-1:0] CODE = SRC_W'(SRC_BASE + g);
    assign hit[g] = src_ticks[g] & (src == CODE);
  end

  assign sel_tick = |hit;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt     <= '0;
      fclk_en <= 1'b0;
    end else if (gate_on && sel_tick) begin
      if (cnt == div) begin
        cnt     <= '0;
        fclk_en <= 1'b1;
      end else begin
        cnt     <= cnt + DIV_W'(1);
        fclk_en <= 1'b0;
      end
    end else begin
      fclk_en <= 1'b0;
    end
  end

  // R10: a pulse needs a gated, selected tick one cycle earlier
  p_fclk_gated_r10: assert property (@(posedge clk) disable iff (rst)
    fclk_en |-> $past(gate_on && sel_tick));

  // R9: unmapped source codes yield no functional clock
  p_unknown_src_r9: assert property (@(posedge clk) disable iff (rst)
    (src < SRC_BASE || src > SRC_W'(SRC_BASE + NUM_SRC - 1)) |=> !fclk_en);

endmodule

// File: rtl/pclk_slot_ctrl.sv
module pclk_slot_ctrl
  import pclk_slot_pkg::*;
#(
  parameter int   REG_W   = 32,
  parameter int   DIV_W   = 8,
  parameter logic PRESENT = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [REG_W-1:0]   cfg_wdata,
  output logic [REG_W-1:0]   cfg_rdata,
  input  logic [NUM_SRC-1:0] src_ticks,
  input  logic               sleep_req,
  input  logic               deep_req,
  input  logic               periph_idle,
  output logic               clk_gate_on,
  output logic               fclk_en,
  output logic               periph_rst_n,
  output logic               lp_stall,
  output logic               lp_ack
);

  logic [1:0]       mode_q;
  logic             rel_q;
  logic             hold_q;
  logic [SRC_W-1:0] src_q;
  logic [DIV_W-1:0] div_q;

  pclk_cfg_reg #(
    .REG_W   (REG_W),
    .DIV_W   (DIV_W),
    .PRESENT (PRESENT)
  ) u_cfg (
    .clk    (clk),
    .rst    (rst),
    .we     (cfg_we),
    .wdata  (cfg_wdata),
    .mode_q (mode_q),
    .rel_q  (rel_q),
    .hold_q (hold_q),
    .src_q  (src_q),
    .div_q  (div_q),
    .rdata  (cfg_rdata)
  );

  pclk_lp_gate u_gate (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode_q),
    .hold      (hold_q),
    .sleep_req (sleep_req),
    .deep_req  (deep_req),
    .idle      (periph_idle),
    .gate_on   (clk_gate_on),
    .stall     (lp_stall),
    .ack       (lp_ack)
  );

  pclk_fclk_div #(
    .DIV_W (DIV_W)
  ) u_div (
    .clk       (clk),
    .rst       (rst),
    .clr       (mode_q == GM_OFF),
    .gate_on   (clk_gate_on),
    .src       (src_q),
    .div       (div_q),
    .src_ticks (src_ticks),
    .fclk_en   (fclk_en)
  );

  // R11: reset release bit drives the peripheral reset directly
  assign periph_rst_n = rel_q;

endmodule

// File: tb/pclk_slot_ctrl_tb.sv
module pclk_slot_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [3:0]  src_ticks = '0;
  logic        sleep_req = 1'b0;
  logic        deep_req = 1'b0;
  logic        periph_idle = 1'b0;
  logic        clk_gate_on, fclk_en, periph_rst_n, lp_stall, lp_ack;

  always #2 clk = ~clk;

  pclk_slot_ctrl dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .src_ticks(src_ticks), .sleep_req(sleep_req),
    .deep_req(deep_req), .periph_idle(periph_idle), .clk_gate_on(clk_gate_on),
    .fclk_en(fclk_en), .periph_rst_n(periph_rst_n), .lp_stall(lp_stall),
    .lp_ack(lp_ack)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  int pulses = 0;

  // reference state, built from the requirements
  logic [1:0] m_mode; logic m_rel, m_hold; logic [2:0] m_src; logic [7:0] m_div;
  logic m_gate, m_stall, m_ack, m_fe; logic [7:0] m_cnt;

  always @(posedge clk) begin
    logic lp_any, lp_eff, need, gn, tk;
    int k;
    if (rst) begin
      m_mode = 0; m_rel = 0; m_hold = 0; m_src = 0; m_div = 0;
      m_gate = 0; m_stall = 0; m_ack = 0; m_fe = 0; m_cnt = 0;
    end else begin
      lp_any = sleep_req | deep_req;
      lp_eff = (m_mode == 2) ? lp_any :
               (m_mode == 3) ? (deep_req | (sleep_req & ~m_hold)) : 1'b0;
      need = lp_eff & ~periph_idle;
      case (m_mode)
        2'd0: gn = 1'b0;
        2'd1: gn = 1'b1;
        2'd2: gn = ~periph_idle;
        default: gn = ~(lp_eff & periph_idle);
      endcase
      k = int'(m_src) - 2;
      tk = (k >= 0 && k <= 3) ? src_ticks[k] : 1'b0;
      if (m_mode == 0) begin m_cnt = 0; m_fe = 0; end
      else if (m_gate && tk) begin
        if (m_cnt == m_div) begin m_cnt = 0; m_fe = 1; end
        else begin m_cnt = m_cnt + 8'd1; m_fe = 0; end
      end else m_fe = 0;
      m_gate = gn; m_stall = need; m_ack = lp_any & ~need;
      if (cfg_we) begin
        if (m_mode == 0) begin m_src = cfg_wdata[6:4]; m_div = cfg_wdata[15:8]; end
        m_mode = cfg_wdata[1:0]; m_rel = cfg_wdata[2]; m_hold = cfg_wdata[3];
      end
    end
  end

  function automatic logic [31:0] mkw(input logic [1:0] md, input logic rl,
                                      input logic hd, input logic [2:0] sc,
                                      input logic [7:0] dv);
    mkw = {1'b1, 15'd0, dv, 1'b0, sc, hd, rl, md};
  endfunction

  function automatic string gate_tag();
    case (m_mode)
      2'd0: gate_tag = "R2";
      2'd1: gate_tag = "R3";
      2'd2: gate_tag = "R4";
      default: gate_tag = m_hold ? "R6" : "R5";
    endcase
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk(gate_tag(), "gate", 32'(clk_gate_on), 32'(m_gate));
    chk("R7", "stall", 32'(lp_stall), 32'(m_stall));
    chk("R7", "ack", 32'(lp_ack), 32'(m_ack));
    chk((m_src < 2 || m_src > 5) ? "R9" : "R10", "fclk", 32'(fclk_en), 32'(m_fe));
    chk("R8", "readback", cfg_rdata, {1'b1, 15'd0, m_div, 1'b0, m_src, m_hold, m_rel, m_mode});
    chk("R11", "rst_n", 32'(periph_rst_n), 32'(m_rel));
    if (fclk_en) pulses++;
  endtask

  task automatic step(input logic we, input logic [31:0] wd, input logic sl,
                      input logic dp, input logic id, input logic [3:0] tk);
    cfg_we = we; cfg_wdata = wd; sleep_req = sl; deep_req = dp;
    periph_idle = id; src_ticks = tk;
    @(posedge clk);
    @(negedge clk);
    check_all();
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1", "gate", 32'(clk_gate_on), 0);
    chk("R1", "fclk", 32'(fclk_en), 0);
    chk("R1", "stall/ack", 32'({lp_stall, lp_ack}), 0);
    chk("R1", "rst_n", 32'(periph_rst_n), 0);
    chk("R1", "readback", cfg_rdata, 32'h8000_0000);

    // R8: source/divider write ignored once mode is nonzero
    step(1, mkw(2'd1, 1, 0, 3'd4, 8'd3), 0, 0, 0, 4'h0);
    step(1, mkw(2'd1, 1, 0, 3'd2, 8'd7), 0, 0, 0, 4'h0);
    step(0, 0, 0, 0, 0, 4'h0);
    chk("R8", "src held", 32'(cfg_rdata[6:4]), 32'd4);

    // R9: unmapped code 7, all ticks on
    step(1, mkw(2'd0, 0, 0, 3'd7, 8'd0), 0, 0, 0, 4'h0);
    step(1, mkw(2'd1, 0, 0, 3'd7, 8'd0), 0, 0, 0, 4'h0);
    pulses = 0;
    for (int i = 0; i < 20; i++) step(0, 0, 0, 0, 0, 4'hF);
    chk("R9", "pulses code 7", 32'(pulses), 0);

    // R10: 32 kHz source (code 5), divide by 3
    step(1, mkw(2'd0, 1, 0, 3'd5, 8'd2), 0, 0, 0, 4'h0);
    step(1, mkw(2'd1, 1, 0, 3'd5, 8'd2), 0, 0, 0, 4'h0);
    step(0, 0, 0, 0, 0, 4'h0);
    pulses = 0;
    for (int i = 0; i < 30; i++) step(0, 0, 0, 0, 0, 4'h8);
    step(0, 0, 0, 0, 0, 4'h0);
    chk("R10", "pulses div3", 32'(pulses), 32'd10);

    // R6: keep-in-sleep mode 3, sleep only, busy then deep
    step(1, mkw(2'd3, 1, 1, 3'd5, 8'd2), 0, 0, 0, 4'h0);
    step(0, 0, 1, 0, 0, 4'h0);
    step(0, 0, 1, 0, 1, 4'h0);
    chk("R6", "gate kept in sleep", 32'(clk_gate_on), 1);
    step(0, 0, 1, 1, 0, 4'h0);
    chk("R6", "deep busy stall", 32'(lp_stall), 1);
    step(0, 0, 1, 1, 1, 4'h0);
    chk("R7", "stall released", 32'(lp_stall), 0);

    // random mix, mode writes overlapping request/idle/tick changes
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] md;
      md = ($urandom % 3 == 0) ? 2'd0 : 2'($urandom);
      step(($urandom % 6) == 0,
           mkw(md, 1'($urandom), 1'($urandom), 3'($urandom), 8'($urandom % 4)),
           ($urandom % 3) == 0, ($urandom % 5) == 0, 1'($urandom), 4'($urandom));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule